// File: doc/BRIEF.md
# Tagged Arithmetic Unit with Trap Request

This execution unit performs add and subtract on two 64-bit operands whose two least significant bits are treated as a type tag. A tag that is not zero marks an operand as the wrong type for integer arithmetic. There are four operations. Two of them only report a bad tag through the overflow flag. The other two turn a bad tag, or a 32-bit signed overflow, into a trap request and withhold the write-back.

Each operation produces a 64-bit result and a register write enable. The unit keeps two condition-code groups: a narrow group that looks only at bits 31:0 and a wide group that looks at all 64 bits. Both groups are state held inside the unit. They change only when an operation writes back, so a trapped operation leaves them as they were.

Operations enter over a valid/ready stream and leave over another valid/ready stream. The output side is one register stage. While a result is shown and the consumer holds `out_ready` low, the result, write enable, trap request and trap code are held steady and no new operation is accepted. The unit takes a new operation in the same cycle that the shown result is consumed. The condition-code pins are plain status outputs and are always visible.

Top module: `tagalu_unit`

## Requirements
- R1: `op` selects the operation: 0 is add with flags, 1 is subtract with flags, 2 is add with trap, 3 is subtract with trap. The result is `opa + opb` or `opa - opb`, modulo 2^64.
- R2: The narrow group `icc` holds N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. N is result bit 31. Z is set when result bits 31:0 are all zero. C is the carry out of bit 31 for add and the borrow for subtract (`opa[31:0]` unsigned-less-than `opb[31:0]`). Operand bits above 31 never affect any of these four flags.
- R3: The wide group `xcc` uses the same bit layout over all 64 bits. Add C is set when the result is unsigned-less-than `opa`; subtract C is set when `opa` is unsigned-less-than `opb`. The wide V ignores the tags.
- R4: Signed overflow is computed at bit 31 for `icc` and at bit 63 for `xcc`. For add, it is set when both operand sign bits are equal and the result sign bit differs from them. For subtract, it is set when the operand sign bits differ and the result sign bit differs from the sign bit of `opa`.
- R5: For operations 0 and 1, the narrow V is also set when bits 1:0 of either operand are nonzero. `wr_en` is 1 and `trap_req` is 0.
- R6: For operations 2 and 3, a nonzero tag on either operand, or a narrow signed overflow, gives `trap_req` = 1 and `wr_en` = 0, and leaves both groups unchanged.
- R7: While `trap_req` is 1, `trap_code` is 8'h23 when parameter `ARCH64` is 1 and 8'h0a when it is 0. Otherwise `trap_code` is 0.
- R8: An operation 2 or 3 that does not trap writes back. It updates N, Z and C in both groups and clears V in both groups.
- R9: An operation accepted at a clock edge is shown with `out_valid` = 1 right after that edge. A synchronous reset clears `out_valid`, `wr_en`, `trap_req`, `trap_code`, `icc` and `xcc`.
- R10: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, the shown outputs stay the same into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can take an operation this cycle |
| op | input | 2 | Operation select |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| out_valid | output | 1 | A completed operation is shown |
| out_ready | input | 1 | The consumer takes the shown operation |
| result | output | 64 | Sum or difference |
| wr_en | output | 1 | Write the result back |
| trap_req | output | 1 | The operation trapped |
| trap_code | output | 8 | Trap type while trapping, else 0 |
| icc | output | 4 | Narrow condition codes {N,Z,V,C} |
| xcc | output | 4 | Wide condition codes {N,Z,V,C} |

## Verification
The hardest case to observe is a trap that must leave both condition-code groups as they were. This can only be seen if a trapping operation directly follows a write-back that left known, non-zero flags. The stimulus sends such pairs back to back: a carry-producing add followed by a tag-only trap, an arithmetic-only trap and a combined trap. It also sends operands whose low words carry out while their high words do not, and high words that overflow while the low words do not. This separates the two groups. A later phase drops `out_ready` at random so that traps and write-backs are held under back-pressure.

// File: rtl/tagalu_pkg.sv
package tagalu_pkg;

  typedef enum logic [1:0] {
    OP_TADD      = 2'd0,
    OP_TSUB      = 2'd1,
    OP_TADD_TRAP = 2'd2,
    OP_TSUB_TRAP = 2'd3
  } tag_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccode_t;

  localparam int TT_W = 8;
  localparam logic [TT_W-1:0] TT_WIDE   = 8'h23;
  localparam logic [TT_W-1:0] TT_NARROW = 8'h0a;

endpackage

// File: rtl/tagalu_adder.sv
module tagalu_adder #(
  parameter int DATA_W = 64,
  parameter int LOW_W  = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] res,
  output logic              carry_lo,
  output logic              carry_hi,
  output logic              ovf_lo,
  output logic              ovf_hi
);
  localparam int HIGH_W = DATA_W - LOW_W;

  logic [DATA_W-1:0] b_eff;
  logic [LOW_W:0]    lo_sum;
  logic [HIGH_W:0]   hi_sum;

  // Subtract is add of the inverted operand plus one; carries are split at
  // the narrow boundary so the low word's carry-out is available directly.
  always_comb begin
    b_eff  = sub ? ~b : b;
    lo_sum = {1'b0, a[LOW_W-1:0]} + {1'b0, b_eff[LOW_W-1:0]} + {{LOW_W{1'b0}}, sub};
    hi_sum = {1'b0, a[DATA_W-1:LOW_W]} + {1'b0, b_eff[DATA_W-1:LOW_W]}
           + {{HIGH_W{1'b0}}, lo_sum[LOW_W]};
    res    = {hi_sum[HIGH_W-1:0], lo_sum[LOW_W-1:0]};
    // Borrow is the inverted carry for subtract.
    carry_lo = lo_sum[LOW_W] ^ sub;
    carry_hi = hi_sum[HIGH_W] ^ sub;
    ovf_lo = (a[LOW_W-1] == b_eff[LOW_W-1]) && (res[LOW_W-1] != a[LOW_W-1]);
    ovf_hi = (a[DATA_W-1] == b_eff[DATA_W-1]) && (res[DATA_W-1] != a[DATA_W-1]);
  end

endmodule

// File: rtl/tagalu_decide.sv
module tagalu_decide
  import tagalu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LOW_W  = 32,
  parameter int TAG_W  = 2
) (
  input  tag_op_e           op,
  input  logic [DATA_W-1:0] res,
  input  logic              carry_lo,
  input  logic              carry_hi,
  input  logic              ovf_lo,
  input  logic              ovf_hi,
  input  logic [TAG_W-1:0]  tag_a,
  input  logic [TAG_W-1:0]  tag_b,
  output ccode_t            icc_new,
  output ccode_t            xcc_new,
  output logic              do_write,
  output logic              do_trap
);
  logic tag_bad;
  logic trapping;

  always_comb begin
    tag_bad  = (|tag_a) || (|tag_b);
    trapping = (op == OP_TADD_TRAP) || (op == OP_TSUB_TRAP);

    icc_new.n = res[LOW_W-1];
    icc_new.z = (res[LOW_W-1:0] == '0);
    icc_new.c = carry_lo;
    xcc_new.n = res[DATA_W-1];
    xcc_new.z = (res == '0);
    xcc_new.c = carry_hi;

    if (trapping) begin
      // Only a clean operation reaches write-back; overflow is known clear.
      do_trap   = tag_bad || ovf_lo;
      do_write  = !do_trap;
      icc_new.v = 1'b0;
      xcc_new.v = 1'b0;
    end else begin
      do_trap   = 1'b0;
      do_write  = 1'b1;
      icc_new.v = ovf_lo || tag_bad;
      xcc_new.v = ovf_hi;
    end
  end

endmodule

// File: rtl/tagalu_outstage.sv
module tagalu_outstage
  import tagalu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] res_d,
  input  ccode_t            icc_d,
  input  ccode_t            xcc_d,
  input  logic              write_d,
  input  logic              trap_d,
  input  logic [TT_W-1:0]   tt_d,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              trap_req,
  output logic [TT_W-1:0]   trap_code,
  output ccode_t            icc,
  output ccode_t            xcc
);
  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      wr_en     <= 1'b0;
      trap_req  <= 1'b0;
      trap_code <= '0;
      icc       <= '0;
      xcc       <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      result    <= res_d;
      wr_en     <= write_d;
      trap_req  <= trap_d;
      trap_code <= trap_d ? tt_d : '0;
      // Condition codes follow write-back only; a trap leaves them alone.
      if (write_d) begin
        icc <= icc_d;
        xcc <= xcc_d;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      trap_req  <= 1'b0;
      trap_code <= '0;
    end
  end

endmodule

// File: rtl/tagalu_unit.sv
module tagalu_unit
  import tagalu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LOW_W  = 32,
  parameter int TAG_W  = 2,
  parameter bit ARCH64 = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              trap_req,
  output logic [TT_W-1:0]   trap_code,
  output logic [3:0]        icc,
  output logic [3:0]        xcc
);
  tag_op_e           op_e;
  logic              is_sub;
  logic [DATA_W-1:0] sum;
  logic              c_lo, c_hi, v_lo, v_hi;
  ccode_t            icc_d, xcc_d, icc_q, xcc_q;
  logic              write_d, trap_d;
  logic [TT_W-1:0]   tt_sel;

  assign op_e   = tag_op_e'(op);
  assign is_sub = (op_e == OP_TSUB) || (op_e == OP_TSUB_TRAP);

  generate
    if (ARCH64) begin : g_tt_wide
      assign tt_sel = TT_WIDE;
    end else begin : g_tt_narrow
      assign tt_sel = TT_NARROW;
    end
  endgenerate

  tagalu_adder #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_adder (
    .a(opa), .b(opb), .sub(is_sub), .res(sum),
    .carry_lo(c_lo), .carry_hi(c_hi), .ovf_lo(v_lo), .ovf_hi(v_hi)
  );

  tagalu_decide #(.DATA_W(DATA_W), .LOW_W(LOW_W), .TAG_W(TAG_W)) u_decide (
    .op(op_e), .res(sum), .carry_lo(c_lo), .carry_hi(c_hi),
    .ovf_lo(v_lo), .ovf_hi(v_hi),
    .tag_a(opa[TAG_W-1:0]), .tag_b(opb[TAG_W-1:0]),
    .icc_new(icc_d), .xcc_new(xcc_d), .do_write(write_d), .do_trap(trap_d)
  );

  tagalu_outstage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .res_d(sum), .icc_d(icc_d), .xcc_d(xcc_d), .write_d(write_d),
    .trap_d(trap_d), .tt_d(tt_sel), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .wr_en(wr_en),
    .trap_req(trap_req), .trap_code(trap_code), .icc(icc_q), .xcc(xcc_q)
  );

  assign icc = icc_q;
  assign xcc = xcc_q;

endmodule

// File: rtl/tagalu_chk.sv
module tagalu_chk #(
  parameter int DATA_W = 64,
  parameter bit ARCH64 = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] result,
  input logic              wr_en,
  input logic              trap_req,
  input logic [7:0]        trap_code,
  input logic [3:0]        icc,
  input logic [3:0]        xcc
);
  localparam logic [7:0] EXP_TT = ARCH64 ? 8'h23 : 8'h0a;

  assert_trap_blocks_write_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && trap_req |-> !wr_en);

  assert_trap_keeps_cc_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && trap_req |-> $stable(icc) && $stable(xcc));

  assert_trap_code_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && trap_req |-> trap_code == EXP_TT);

  assert_code_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !trap_req |-> trap_code == 8'h00);

  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  assert_idle_clean_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !wr_en && !trap_req);

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  assert_stall_holds_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(wr_en)
                                && $stable(trap_req));

endmodule

bind tagalu_unit tagalu_chk #(.DATA_W(DATA_W), .ARCH64(ARCH64)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .result(result),
  .wr_en(wr_en), .trap_req(trap_req), .trap_code(trap_code),
  .icc(icc), .xcc(xcc)
);

// File: tb/tb_tagalu_unit.sv
module tb_tagalu_unit;

  typedef struct {
    logic [63:0] res;
    logic        we;
    logic        tr;
    logic [7:0]  tt;
    logic [3:0]  icc;
    logic [3:0]  xcc;
    int          acc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op = 2'd0;
  logic [63:0] opa = '0, opb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] result;
  logic        wr_en, trap_req;
  logic [7:0]  trap_code;
  logic [3:0]  icc, xcc;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;
  bit done = 1'b0;
  exp_t sb[$];
  logic [3:0] m_icc = '0, m_xcc = '0;
  bit hold_prev = 1'b0;
  logic [63:0] hold_res;

  always #4 clk = ~clk;

  tagalu_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .opa(opa), .opb(opb), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .wr_en(wr_en),
    .trap_req(trap_req), .trap_code(trap_code), .icc(icc), .xcc(xcc)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #2 out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference model, written from the requirements.
  task automatic send(input logic [1:0] o, input logic [63:0] a, input logic [63:0] b);
    exp_t e;
    logic [63:0] r;
    logic sub, c32, c64, v32, v64, tag;
    sub = o[0];
    r   = sub ? a - b : a + b;                                   // R1
    c32 = sub ? (a[31:0] < b[31:0]) : (r[31:0] < a[31:0]);       // R2
    c64 = sub ? (a < b) : (r < a);                               // R3
    v32 = sub ? ((a[31] != b[31]) && (r[31] != a[31]))
              : ((a[31] == b[31]) && (r[31] != a[31]));          // R4
    v64 = sub ? ((a[63] != b[63]) && (r[63] != a[63]))
              : ((a[63] == b[63]) && (r[63] != a[63]));
    tag = (a[1:0] != 2'b00) || (b[1:0] != 2'b00);
    e.res = r;
    if (!o[1]) begin                                             // R5
      m_icc = {r[31], r[31:0] == 32'd0, v32 | tag, c32};
      m_xcc = {r[63], r == 64'd0, v64, c64};
      e.we = 1'b1; e.tr = 1'b0; e.tt = 8'h00;
    end else if (tag || v32) begin                               // R6 R7
      e.we = 1'b0; e.tr = 1'b1; e.tt = 8'h23;
    end else begin                                               // R8
      m_icc = {r[31], r[31:0] == 32'd0, 1'b0, c32};
      m_xcc = {r[63], r == 64'd0, 1'b0, c64};
      e.we = 1'b1; e.tr = 1'b0; e.tt = 8'h00;
    end
    e.icc = m_icc;
    e.xcc = m_xcc;
    @(negedge clk);
    in_valid = 1'b1; op = o; opa = a; opb = b;
    while (!in_ready) @(negedge clk);
    e.acc = cyc + 1;
    sb.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_prev) begin
        check(out_valid && result == hold_res, "R10", "held result", result, hold_res);
      end
      hold_prev = out_valid && !out_ready;
      hold_res  = result;
      if (out_valid && !out_ready) begin
        check(!in_ready, "R10", "in_ready under stall", {63'd0, in_ready}, 64'd0);
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9", "unexpected output", {63'd0, out_valid}, 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (!stall_mode)
            check(cyc == e.acc, "R9", "latency", 64'(cyc), 64'(e.acc));
          check(wr_en == e.we, "R5/R6/R8", "wr_en", {63'd0, wr_en}, {63'd0, e.we});
          check(trap_req == e.tr, "R6", "trap_req", {63'd0, trap_req}, {63'd0, e.tr});
          check(trap_code == e.tt, "R7", "trap_code", {56'd0, trap_code}, {56'd0, e.tt});
          if (e.we) check(result == e.res, "R1", "result", result, e.res);
          check(icc == e.icc, "R2/R4", "icc", {60'd0, icc}, {60'd0, e.icc});
          check(xcc == e.xcc, "R3/R4", "xcc", {60'd0, xcc}, {60'd0, e.xcc});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check(!out_valid && !wr_en && !trap_req, "R9", "outputs after reset",
          {61'd0, out_valid, wr_en, trap_req}, 64'd0);
    check(icc == 4'd0 && xcc == 4'd0, "R9", "cc after reset", {56'd0, icc, xcc}, 64'd0);
    check(in_ready, "R10", "in_ready idle", {63'd0, in_ready}, 64'd1);

    // Directed corners
    send(2'd0, 64'h0000_0000_ffff_fff0, 64'h0000_0000_0000_0010); // R2 low carry, no wide carry
    send(2'd2, 64'h0000_0000_0000_0004, 64'h0000_0000_0000_0001); // R6 tag-only trap, cc kept
    send(2'd2, 64'h0000_0000_7fff_fffc, 64'h0000_0000_0000_0004); // R6 arith-only trap
    send(2'd3, 64'h0000_0000_8000_0001, 64'h0000_0000_0000_0004); // R6 both at once
    send(2'd1, 64'h1234_5678_0000_0010, 64'h1234_5678_0000_0010); // zero result R2 R3
    send(2'd0, 64'h0000_0000_7fff_fffc, 64'h0000_0000_0000_0004); // R4 V32 no trap, R5
    send(2'd0, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0008); // R5 tag sets V32
    send(2'd0, 64'h7fff_fff0_0000_0000, 64'h0000_0010_0000_0000); // R4 wide overflow only
    send(2'd0, 64'hffff_ffff_0000_0000, 64'h0000_0001_0000_0000); // R3 wide carry, Z64
    send(2'd1, 64'h0000_0000_0000_0004, 64'h0000_0000_0000_0008); // R3 borrow both
    send(2'd3, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0004); // R8 borrow low, no trap
    send(2'd2, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000); // R8 clears V, wide wrap
    send(2'd1, 64'h0000_0000_8000_0000, 64'h0000_0000_0000_0004); // R4 sub overflow
    send(2'd3, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0002); // R6 tag on second operand

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (($urandom % 4) != 0) a[1:0] = 2'b00;
      if (($urandom % 4) != 0) b[1:0] = 2'b00;
      if (($urandom % 3) == 0) a[31:0] = 32'h7fff_fff0 + 32'($urandom % 32) * 4;
      send(2'($urandom % 4), a, b);
    end

    // Back-pressure phase
    stall_mode = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (($urandom % 3) != 0) a[1:0] = 2'b00;
      if (($urandom % 3) != 0) b[1:0] = 2'b00;
      send(2'($urandom % 4), a, b);
    end
    while (sb.size() != 0) @(negedge clk);
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    check(!out_valid, "R9", "drained", {63'd0, out_valid}, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule